// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a clocked host read and write an external asynchronous static RAM of 256K words by 16 bits. The host presents a request made of an 18-bit word address, 16-bit write data, a 2-bit lane mask and a write flag. It holds `req` high until `ready` pulses. The controller latches the request and drives the RAM's pins. These are a dual-polarity chip select (one low-active, one high-active), write and output strobes, one low-active enable per byte lane, the address, and a shared tri-state data bus.

Every strobe width is a whole number of clocks. Package functions compute each count as a ceiling division of the RAM's nanosecond limits by the clock-period parameter, so the minimum limits hold at any period. A read holds the output strobe low for the full access window and captures the bus on its last cycle. Disabled lanes read as zero. A write first spends a setup phase with the bus released and the output strobe high. It then drives data through the write pulse and releases the bus as the pulse ends. One deselected recovery cycle closes every transfer, and `ready` pulses during that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During the strobe phases of a transfer `ram_cs_n` is 0 and `ram_cs` is 1, and `ram_addr` carries the accepted address. In idle and in recovery the RAM is deselected (`ram_cs_n`=1, `ram_cs`=0).
- R2: While selected, `ram_lb_n` equals the inverse of mask bit 0 (data bits 7:0) and `ram_ub_n` equals the inverse of mask bit 1 (bits 15:8). Both are 1 while deselected.
- R3: During a write `ram_oe_n` stays 1 throughout, `ram_we_n` is 0 only in the pulse phase, and the controller drives `ram_dq` only while `ram_we_n` is 0. `ram_we_n` and `ram_oe_n` are never both 0.
- R4: A read keeps `ram_we_n` at 1 and `ram_oe_n` at 0 for the whole read strobe. It captures the bus on the strobe's last cycle, returns 0 in each lane whose mask bit is 0, and presents `rdata` while `ready` is 1.
- R5: The read strobe lasts the ceiling of max(70, 70, 35, 70) ns divided by the clock period, which is 9 cycles at 8 ns. `ready` is seen after the 10th rising edge, counting the accepting edge as the first.
- R6: A write has a setup phase of ceil(30 ns / period) cycles with `ram_we_n` at 1. The pulse lasts the largest of ceil(50/T), ceil(60/T) minus setup, and ceil(70/T) minus setup minus 1. At 8 ns these are 4 and 7 cycles, and `ready` is seen after the 12th rising edge.
- R7: While `ram_we_n` is 0 the address and lanes stay stable. Write data is on the bus at least 30 ns before `ram_we_n` rises, and the address is valid at least 60 ns before.
- R8: `ready` is 1 for exactly one cycle. If `req` stays high, the next request is accepted after one idle cycle, so a follow-on write shows `ready` 13 rising edges after the previous `ready`.
- R9: While `rst_n` is 0, and just after it rises, the RAM is deselected, all strobes and lane enables are 1, `ready` is 0 and `rdata` is 0.
- R10: A mask of 00 enables no lane. Such a write leaves the stored word unchanged, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request, held until ready |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ready |
| ram_cs_n | output | 1 | Low-active chip select |
| ram_cs | output | 1 | High-active chip select |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output strobe, active low |
| ram_lb_n | output | 1 | Lower lane enable, active low |
| ram_ub_n | output | 1 | Upper lane enable, active low |
| ram_addr | output | 18 | RAM address |
| ram_dq | inout | 16 | Bidirectional RAM data |

## Verification
The completion pulse of one transfer and the host's still-raised request for the next can coincide: the request is already present in the recovery cycle and waits through the idle cycle. The bench provokes this by keeping `req` high through a read's `ready` and switching the fields to a write in that same cycle. It then judges that `ready` drops, that the write completes exactly 13 edges later, and that reading back returns the new word. A timed RAM model in the bench also checks the bus turnaround and the strobe widths of both transfers.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_ACCESS,
    ST_WRITE_SETUP,
    ST_WRITE_PULSE,
    ST_RECOVER
  } ctl_state_e;

  // RAM limits in nanoseconds
  localparam int T_RD_CYCLE    = 70;
  localparam int T_ADDR_ACC    = 70;
  localparam int T_OE_ACC      = 35;
  localparam int T_LANE_ACC    = 70;
  localparam int T_WR_CYCLE    = 70;
  localparam int T_WR_PULSE    = 50;
  localparam int T_DATA_SETUP  = 30;
  localparam int T_ADDR_TO_END = 60;
  localparam int T_OUT_FLOAT   = 30;

  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int read_cycles(input int period_ns);
    int n;
    n = imax(ns_to_cycles(T_RD_CYCLE, period_ns), ns_to_cycles(T_ADDR_ACC, period_ns));
    n = imax(n, ns_to_cycles(T_OE_ACC, period_ns));
    n = imax(n, ns_to_cycles(T_LANE_ACC, period_ns));
    return imax(n, 1);
  endfunction

  function automatic int setup_cycles(input int period_ns);
    return imax(ns_to_cycles(T_OUT_FLOAT, period_ns), 1);
  endfunction

  function automatic int pulse_cycles(input int period_ns);
    int s;
    int n;
    s = setup_cycles(period_ns);
    n = imax(ns_to_cycles(T_WR_PULSE, period_ns), ns_to_cycles(T_DATA_SETUP, period_ns));
    n = imax(n, ns_to_cycles(T_ADDR_TO_END, period_ns) - s);
    n = imax(n, ns_to_cycles(T_WR_CYCLE, period_ns) - s - 1);
    return imax(n, 1);
  endfunction

endpackage

// File: rtl/sram_timing_seq.sv
`timescale 1ns/100ps
module sram_timing_seq import sram_ctrl_pkg::*; #(
  parameter int CLK_NS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_wr,
  output logic       accept,
  output ctl_state_e state,
  output logic       rd_sample,
  output logic       done
);
  localparam int READ_N  = read_cycles(CLK_NS);
  localparam int SETUP_N = setup_cycles(CLK_NS);
  localparam int PULSE_N = pulse_cycles(CLK_NS);
  localparam int MAX_N   = imax(imax(READ_N, SETUP_N), PULSE_N);
  localparam int CNT_W   = $clog2(MAX_N + 1);

  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign accept    = (state == ST_IDLE) && req;
  assign rd_sample = (state == ST_READ_ACCESS) && cnt_zero;
  assign done      = (state == ST_RECOVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            if (req_wr) begin
              state <= ST_WRITE_SETUP;
              cnt   <= CNT_W'(SETUP_N - 1);
            end else begin
              state <= ST_READ_ACCESS;
              cnt   <= CNT_W'(READ_N - 1);
            end
          end
        end
        ST_READ_ACCESS: begin
          if (cnt_zero) state <= ST_RECOVER;
          else          cnt   <= cnt - 1'b1;
        end
        ST_WRITE_SETUP: begin
          if (cnt_zero) begin
            state <= ST_WRITE_PULSE;
            cnt   <= CNT_W'(PULSE_N - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE_PULSE: begin
          if (cnt_zero) state <= ST_RECOVER;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/100ps
module sram_pin_drive import sram_ctrl_pkg::*; #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input  ctl_state_e        state,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]  mask_q,
  output logic              sel_n,
  output logic              sel,
  output logic              we_n,
  output logic              oe_n,
  output logic [LANES-1:0]  lane_n,
  output logic [ADDR_W-1:0] addr,
  output logic              bus_drive
);
  logic active;

  always_comb begin
    active = (state == ST_READ_ACCESS) || (state == ST_WRITE_SETUP) ||
             (state == ST_WRITE_PULSE);
    sel_n     = !active;
    sel       = active;
    we_n      = (state != ST_WRITE_PULSE);
    oe_n      = (state != ST_READ_ACCESS);
    bus_drive = (state == ST_WRITE_PULSE);
    addr      = addr_q;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = !(active && mask_q[g]);
  end
endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/100ps
module sram_read_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [LANES-1:0]  mask_q,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lane_q <= '0;
      else if (sample) lane_q <= mask_q[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end
    assign rdata[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/100ps
module sram_lane_ctrl import sram_ctrl_pkg::*; #(
  parameter int CLK_NS = 8,
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              ram_cs_n,
  output logic              ram_cs,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic              ram_lb_n,
  output logic              ram_ub_n,
  output logic [ADDR_W-1:0] ram_addr,
  inout  wire  [DATA_W-1:0] ram_dq
);
  localparam int LANES = 2;

  ctl_state_e        state;
  logic              accept;
  logic              rd_sample;
  logic              xfer_done;
  logic              bus_drive;
  logic [LANES-1:0]  lane_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  sram_timing_seq #(.CLK_NS(CLK_NS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_wr    (req_wr),
    .accept    (accept),
    .state     (state),
    .rd_sample (rd_sample),
    .done      (xfer_done)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pins (
    .state     (state),
    .addr_q    (addr_q),
    .mask_q    (mask_q),
    .sel_n     (ram_cs_n),
    .sel       (ram_cs),
    .we_n      (ram_we_n),
    .oe_n      (ram_oe_n),
    .lane_n    (lane_n),
    .addr      (ram_addr),
    .bus_drive (bus_drive)
  );

  sram_read_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (rd_sample),
    .mask_q (mask_q),
    .bus_in (ram_dq),
    .rdata  (rdata)
  );

  assign ram_lb_n = lane_n[0];
  assign ram_ub_n = lane_n[1];
  assign ready    = xfer_done;
  assign ram_dq   = bus_drive ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/100ps
module sram_lane_ctrl_chk import sram_ctrl_pkg::*; #(
  parameter int CLK_NS = 8,
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ram_cs_n,
  input logic              ram_cs,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_lb_n,
  input logic              ram_ub_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ready,
  input logic              bus_drive
);
  localparam int READ_N  = read_cycles(CLK_NS);
  localparam int PULSE_N = pulse_cycles(CLK_NS);

  logic [7:0] we_low_cnt;
  logic [7:0] oe_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
    end else begin
      we_low_cnt <= !ram_we_n ? ((we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1) : '0;
      oe_low_cnt <= !ram_oe_n ? ((oe_low_cnt == 8'hFF) ? oe_low_cnt : oe_low_cnt + 1'b1) : '0;
    end
  end

  // R1
  sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_n == !ram_cs);

  // R2
  lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_n |-> (ram_lb_n && ram_ub_n));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n);

  // R3
  drive_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (ram_oe_n && $past(ram_oe_n) && !ram_we_n));

  // R5
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> (oe_low_cnt >= 8'(READ_N)));

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_cnt >= 8'(PULSE_N)));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && !$past(ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_lb_n) && $stable(ram_ub_n)));

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.CLK_NS(CLK_NS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ram_cs_n  (ram_cs_n),
  .ram_cs    (ram_cs),
  .ram_we_n  (ram_we_n),
  .ram_oe_n  (ram_oe_n),
  .ram_lb_n  (ram_lb_n),
  .ram_ub_n  (ram_ub_n),
  .ram_addr  (ram_addr),
  .ready     (ready),
  .bus_drive (bus_drive)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/100ps
module sram_lane_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        ready;
  logic [15:0] rdata;
  logic        ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n;
  logic [17:0] ram_addr;
  wire  [15:0] dq;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .ready(ready), .rdata(rdata),
    .ram_cs_n(ram_cs_n), .ram_cs(ram_cs), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n), .ram_addr(ram_addr), .ram_dq(dq)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- timed RAM model ----------------
  logic [15:0] mem [256];
  real  t_addr = 0.0, t_oe = 0.0, t_we = 0.0, t_dq = 0.0, t_lane = 0.0;
  real  w_tdq, w_taddr;
  logic [15:0] m_val = '0;
  logic        m_lo = 1'b0, m_hi = 1'b0;
  logic [17:0] seen_addr = '0;
  logic [17:0] w_addr;
  logic [15:0] w_data;
  logic        w_lo, w_hi;
  logic        w_sel = 1'b0;

  assign dq[7:0]  = m_lo ? m_val[7:0]  : 8'bz;
  assign dq[15:8] = m_hi ? m_val[15:8] : 8'bz;

  always @(ram_addr)           t_addr = $realtime;
  always @(negedge ram_oe_n)   t_oe   = $realtime;
  always @(negedge ram_we_n)   t_we   = $realtime;
  always @(ram_lb_n, ram_ub_n) t_lane = $realtime;
  always @(dq)                 t_dq   = $realtime;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    #0.5;
    forever begin
      logic sel, rd;
      sel = !ram_cs_n && ram_cs;
      rd  = sel && ram_we_n && !ram_oe_n;
      if (sel && !ram_we_n) begin
        w_sel = 1'b1; w_addr = ram_addr; w_data = dq;
        w_lo = !ram_lb_n; w_hi = !ram_ub_n; w_tdq = t_dq; w_taddr = t_addr;
      end
      if (rd) seen_addr = ram_addr;
      m_lo = rd && !ram_lb_n;
      m_hi = rd && !ram_ub_n;
      if (($realtime - t_addr >= 70.0) && ($realtime - t_oe >= 35.0) && ($realtime - t_lane >= 70.0))
        m_val = mem[ram_addr[7:0]];
      else
        m_val = 16'hDEAD;
      #1;
    end
  end

  always @(posedge ram_we_n) begin
    if (w_sel) begin
      check(($realtime - t_we) >= 50.0, "R6", "write pulse ns", 32'($rtoi($realtime - t_we)), 32'd50);
      check(($realtime - w_tdq) >= 30.0, "R7", "data setup ns", 32'($rtoi($realtime - w_tdq)), 32'd30);
      check(($realtime - w_taddr) >= 60.0, "R7", "addr to end ns", 32'($rtoi($realtime - w_taddr)), 32'd60);
      if (w_lo) mem[w_addr[7:0]][7:0]  = w_data[7:0];
      if (w_hi) mem[w_addr[7:0]][15:8] = w_data[15:8];
      seen_addr = w_addr;
      w_sel = 1'b0;
    end
  end

  // ---------------- transfer task ----------------
  task automatic do_xfer(input bit wr, input logic [1:0] mask, input logic [17:0] addr,
                         input logic [15:0] data, input bit keep_req,
                         output logic [15:0] rd_o, output int lat,
                         output int we_cyc, output int oe_cyc, output bit bad_lane,
                         output bit bad_strobe, output bit bad_sel);
    req_wr = wr; req_mask = mask; req_addr = addr; req_wdata = data; req = 1'b1;
    lat = 0; we_cyc = 0; oe_cyc = 0; bad_lane = 0; bad_strobe = 0; bad_sel = 0;
    do begin
      @(posedge clk); #1;
      lat++;
      if (!ram_we_n) we_cyc++;
      if (!ram_oe_n) oe_cyc++;
      if (!ram_we_n && !ram_oe_n) bad_strobe = 1;
      if (wr && !ram_oe_n) bad_strobe = 1;
      if (!wr && !ram_we_n) bad_strobe = 1;
      if (ram_cs_n == ram_cs) bad_sel = 1;
      if (!ram_cs_n && (ram_lb_n != !mask[0] || ram_ub_n != !mask[1])) bad_lane = 1;
      if (ram_cs_n && (!ram_lb_n || !ram_ub_n)) bad_lane = 1;
    end while (!ready && lat < 100);
    rd_o = rdata;
    check(ram_cs_n && !ram_cs, "R1", "deselected in ready cycle", {ram_cs_n, ram_cs}, 2'b10);
    if (!keep_req) req = 1'b0;
  endtask

  // {wr, mask, addr, wdata, expected read}
  localparam logic [52:0] VEC [14] = '{
    {1'b1, 2'b11, 18'h00010, 16'hA5C3, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA5C3},
    {1'b1, 2'b01, 18'h00010, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA534},
    {1'b1, 2'b10, 18'h00010, 16'h9876, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'h9834},
    {1'b0, 2'b01, 18'h00010, 16'h0000, 16'h0034},
    {1'b0, 2'b10, 18'h00010, 16'h0000, 16'h9800},
    {1'b1, 2'b11, 18'h3FFFF, 16'hFFFF, 16'h0000},
    {1'b1, 2'b11, 18'h00020, 16'h5555, 16'h0000},
    {1'b1, 2'b00, 18'h00020, 16'h0F0F, 16'h0000},
    {1'b0, 2'b11, 18'h00020, 16'h0000, 16'h5555},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'hFFFF},
    {1'b0, 2'b00, 18'h3FFFF, 16'h0000, 16'h0000}
  };

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    int lat, wec, oec;
    bit bl, bs, bsel;

    // R9: reset state, during and just after reset
    #10;
    check({ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ready} == 7'b1011110,
          "R9", "pins in reset", {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ready}, 7'b1011110);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check({ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ready} == 7'b1011110,
          "R9", "pins after reset", {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ready}, 7'b1011110);
    check(rdata == 16'h0, "R9", "rdata after reset", rdata, 16'h0);

    for (int i = 0; i < 14; i++) begin
      logic        v_wr;
      logic [1:0]  v_mask;
      logic [17:0] v_addr;
      logic [15:0] v_data, v_exp;
      {v_wr, v_mask, v_addr, v_data, v_exp} = VEC[i];
      do_xfer(v_wr, v_mask, v_addr, v_data, 1'b0, rd, lat, wec, oec, bl, bs, bsel);
      check(!bl, "R2", "lane enables vs mask", {ram_lb_n, ram_ub_n}, {2'b0, v_mask});
      check(!bs, "R3", "strobe overlap or wrong strobe", 32'(bs), 32'd0);
      check(!bsel, "R1", "select pair agreement", 32'(bsel), 32'd0);
      if (v_mask != 2'b00)
        check(seen_addr == v_addr, "R1", "address at RAM", seen_addr, v_addr);
      if (v_wr) begin
        check(lat == 12, "R6", "write ready latency", lat, 12);
        check(wec == 7, "R6", "write pulse cycles", wec, 7);
      end else begin
        check(lat == 10, "R5", "read ready latency", lat, 10);
        check(oec == 9, "R5", "read strobe cycles", oec, 9);
        check(rd == v_exp, (v_mask == 2'b11) ? "R4" : "R10", "read data", rd, v_exp);
      end
      @(posedge clk); #1;
      check(!ready, "R8", "ready is one cycle", 32'(ready), 32'd0);
    end

    // R8: back-to-back, req held through ready, read then write
    do_xfer(1'b0, 2'b11, 18'h00010, 16'h0000, 1'b1, rd, lat, wec, oec, bl, bs, bsel);
    check(rd == 16'h9834, "R4", "first of pair read", rd, 16'h9834);
    do_xfer(1'b1, 2'b11, 18'h00020, 16'h6C6C, 1'b0, rd, lat, wec, oec, bl, bs, bsel);
    check(lat == 13, "R8", "held-request write latency", lat, 13);
    check(!bs, "R3", "turnaround strobes", 32'(bs), 32'd0);
    do_xfer(1'b0, 2'b11, 18'h00020, 16'h0000, 1'b0, rd, lat, wec, oec, bl, bs, bsel);
    check(rd == 16'h6C6C, "R8", "back-to-back write readback", rd, 16'h6C6C);

    // R10: write with empty mask leaves the word, then upper-lane-only read
    do_xfer(1'b1, 2'b00, 18'h00020, 16'h0000, 1'b0, rd, lat, wec, oec, bl, bs, bsel);
    do_xfer(1'b0, 2'b10, 18'h00020, 16'h0000, 1'b0, rd, lat, wec, oec, bl, bs, bsel);
    check(rd == 16'h6C00, "R10", "empty-mask write then upper read", rd, 16'h6C00);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule